// File: doc/BRIEF.md
# Four-Way Word-Interleaved Refill Memory

This block is a memory subsystem that answers cache-line refill requests. Its storage is split across four banks. Word address `a` lives in bank `a mod 4` at row `a / 4`, so consecutive words sit in consecutive banks. A line request broadcasts one row address to every bank in the cycle it is accepted. All banks then run their fixed six-cycle access at the same time. The controller streams the four words over a one-word bus, one per cycle, in ascending address order. The whole refill therefore takes 1 + 6 + 4 = 11 cycles instead of four serial eight-cycle accesses.

A second request kind reads a single word from one bank. Single-word reads to different banks may overlap. A single-word read that targets a bank still inside its six-cycle access holds `req_ready` low until that bank is free. A latency output reports the cycle count of the most recent line refill.

The controller is a three-state machine:
- `S_IDLE` accepts requests and forwards single-word results.
- `S_FILL` waits for the banks of a line refill.
- `S_BURST` streams the remaining words.

Its transitions are:
- IDLE→FILL on an accepted line request.
- FILL→BURST when the banks deliver, with word 0 sent in that cycle.
- BURST→IDLE after the last word.

The banks have no write port. After reset, each bank holds a fixed computed pattern.

Top module: `ilv_mem`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `rsp_last` are 0, and `lat_cycles` is 0.
- R2: Word address `a` is stored in bank `a mod 4`, row `a / 4`. Its content is `(a * 32'h0001_0003) ^ 32'h5A5A_0000`, computed in 32 bits.
- R3: A line request (`req_single` = 0) returns the four words of the aligned line `{addr[5:2], 2'b00}` through `+3`. They come in ascending order on four consecutive cycles. The two low address bits are ignored.
- R4: `rsp_last` is 1 only with the fourth word of a line and with every single-word response.
- R5: Call the line request's accept cycle cycle 0. Word 0 appears in cycle 7 and the last word in cycle 10. After the last word, `lat_cycles` reads 11.
- R6: From the cycle after a line request is accepted until the cycle after its last word, `req_ready` is 0.
- R7: A single-word read (`req_single` = 1) accepted in cycle 0 returns its word with `rsp_last` = 1 in cycle 7 and in no other cycle.
- R8: A bank is busy for the 6 cycles after it accepts an access. A single-word read to a busy bank sees `req_ready` = 0 until that bank is free. A single-word read to a free bank is accepted in the next cycle.
- R9: A line request is held off (`req_ready` = 0) while any bank is busy with a single-word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 6 | Word address |
| req_single | input | 1 | 1 = single-word read, 0 = line refill |
| rsp_valid | output | 1 | Response word present |
| rsp_data | output | 32 | Response word |
| rsp_last | output | 1 | Final word of the response |
| lat_cycles | output | 8 | Cycle count of the most recent line refill |

## Verification
The embedded properties check the following on every cycle:
- No bank is ever restarted while busy.
- All banks of a line finish together.
- At most one single-word result appears per cycle.
- A line stream never has a gap before `rsp_last`.
- `req_ready` stays low after a line is accepted.

The bench scenarios cover what those properties cannot:
- the stored contents;
- the exact cycle where words appear;
- the 11-cycle latency figure;
- the length of the bank-busy stall.

The bench sweeps every address as a line request and as a single-word read. It also replays the same-bank, different-bank and line-after-single stall cases.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int WORD_W = 32;
    localparam int LATW   = 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL  = 2'd1,
        S_BURST = 2'd2
    } ctrl_state_t;

    // Fixed content of the word at a global word address.
    function automatic logic [WORD_W-1:0] cell_value(input logic [31:0] a);
        logic [31:0] p;
        p = a * 32'h0001_0003;
        return p ^ 32'h5A5A_0000;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int NB      = 4,
    parameter int ROWS    = 16,
    parameter int LAT     = 6,
    parameter int BANK_ID = 0,
    localparam int W      = ilv_pkg::WORD_W,
    localparam int RW     = $clog2(ROWS),
    localparam int CW     = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] row,
    input  logic          single_in,
    output logic          busy,
    output logic          done,
    output logic          done_single,
    output logic [W-1:0]  rdata
);

    logic [W-1:0]  mem [ROWS];
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] row_q;
    logic          tag_q;

    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            row_q       <= '0;
            tag_q       <= 1'b0;
            done        <= 1'b0;
            done_single <= 1'b0;
            rdata       <= '0;
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= ilv_pkg::cell_value(32'(r * NB + BANK_ID));
            end
        end else begin
            done        <= 1'b0;
            done_single <= 1'b0;
            if (start) begin
                cnt_q <= CW'(LAT);
                row_q <= row;
                tag_q <= single_in;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    rdata       <= mem[row_q];
                    done        <= 1'b1;
                    done_single <= tag_q;
                end
            end
        end
    end

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl #(
    parameter int NB  = 4,
    parameter int AW  = 6,
    localparam int W  = ilv_pkg::WORD_W,
    localparam int IW = $clog2(NB),
    localparam int LW = ilv_pkg::LATW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_single,
    input  logic [AW-1:0] req_addr,
    input  logic [NB-1:0] busy_vec,
    input  logic [NB-1:0] done_vec,
    input  logic [NB-1:0] done_single_vec,
    input  logic [NB*W-1:0] rdata_flat,
    output logic          req_ready,
    output logic          accept,
    output logic          rsp_valid,
    output logic [W-1:0]  rsp_data,
    output logic          rsp_last,
    output logic [LW-1:0] lat_cycles
);
    import ilv_pkg::*;

    ctrl_state_t   state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [LW-1:0] cnt_q;
    logic [IW-1:0] bank_sel;

    assign bank_sel  = req_addr[IW-1:0];
    assign req_ready = (state_q == S_IDLE) &&
                       (req_single ? !busy_vec[bank_sel] : (busy_vec == '0));
    assign accept    = req_valid && req_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept && !req_single) state_d = S_FILL;
            end
            S_FILL: begin
                if (done_vec[0]) begin
                    if (NB == 1) begin
                        state_d = S_IDLE;
                    end else begin
                        state_d = S_BURST;
                        idx_d   = IW'(1);
                    end
                end
            end
            S_BURST: begin
                if (idx_q == IW'(NB - 1)) begin
                    state_d = S_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
        rsp_last  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                for (int b = 0; b < NB; b++) begin
                    if (done_single_vec[b]) begin
                        rsp_valid = 1'b1;
                        rsp_data  = rdata_flat[b*W +: W];
                        rsp_last  = 1'b1;
                    end
                end
            end
            S_FILL: begin
                if (done_vec[0]) begin
                    rsp_valid = 1'b1;
                    rsp_data  = rdata_flat[0 +: W];
                    rsp_last  = (NB == 1);
                end
            end
            S_BURST: begin
                rsp_valid = 1'b1;
                for (int b = 0; b < NB; b++) begin
                    if (idx_q == IW'(b)) rsp_data = rdata_flat[b*W +: W];
                end
                rsp_last = (idx_q == IW'(NB - 1));
            end
            default: ;
        endcase
    end

    // Line refill latency measurement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            lat_cycles <= '0;
        end else begin
            if (accept && !req_single) begin
                cnt_q <= LW'(1);
            end else if (state_q != S_IDLE) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (rsp_valid && rsp_last && state_q != S_IDLE) begin
                lat_cycles <= cnt_q + 1'b1;
            end
        end
    end

    // R4
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);

    // R3
    burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> rsp_valid);

    // R6
    line_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_single) |=> !req_ready);

    // R7
    single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_single_vec));

    // R5
    fill_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && done_vec[0]) |-> (done_vec == '1));

    // R9
    line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_single) |-> (busy_vec == '0));

endmodule

// File: rtl/ilv_mem.sv
module ilv_mem #(
    parameter int NB   = 4,
    parameter int ROWS = 16,
    parameter int LAT  = 6,
    localparam int W   = ilv_pkg::WORD_W,
    localparam int AW  = $clog2(NB * ROWS),
    localparam int IW  = $clog2(NB),
    localparam int LW  = ilv_pkg::LATW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_single,
    output logic          rsp_valid,
    output logic [W-1:0]  rsp_data,
    output logic          rsp_last,
    output logic [LW-1:0] lat_cycles
);

    logic [NB-1:0]   busy_vec;
    logic [NB-1:0]   done_vec;
    logic [NB-1:0]   done_single_vec;
    logic [NB*W-1:0] rdata_flat;
    logic            accept;
    logic [IW-1:0]   bank_sel;
    logic [AW-IW-1:0] row_sel;

    assign bank_sel = req_addr[IW-1:0];
    assign row_sel  = req_addr[AW-1:IW];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic start_b;
        assign start_b = accept && (!req_single || bank_sel == IW'(b));
        ilv_bank #(
            .NB(NB), .ROWS(ROWS), .LAT(LAT), .BANK_ID(b)
        ) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start_b),
            .row        (row_sel),
            .single_in  (req_single),
            .busy       (busy_vec[b]),
            .done       (done_vec[b]),
            .done_single(done_single_vec[b]),
            .rdata      (rdata_flat[b*W +: W])
        );
    end

    ilv_ctrl #(.NB(NB), .AW(AW)) i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_single     (req_single),
        .req_addr       (req_addr),
        .busy_vec       (busy_vec),
        .done_vec       (done_vec),
        .done_single_vec(done_single_vec),
        .rdata_flat     (rdata_flat),
        .req_ready      (req_ready),
        .accept         (accept),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data),
        .rsp_last       (rsp_last),
        .lat_cycles     (lat_cycles)
    );

endmodule

// File: tb/test_ilv_mem.sv
module test_ilv_mem;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_addr = '0;
    logic        req_single = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_last;
    logic [7:0]  lat_cycles;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    ilv_mem i_ilv_mem (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_single(req_single), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_last(rsp_last), .lat_cycles(lat_cycles)
    );

    function automatic logic [31:0] expw(input int a);
        logic [31:0] p;
        p = 32'(a) * 32'h0001_0003;
        return p ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Line refill: accept cycle C0, words at C7..C10, latency 11
    task automatic line_req(input int a);
        bit quiet;
        int base;
        base = a & ~3;
        @(negedge clk);
        req_valid = 1'b1; req_single = 1'b0; req_addr = 6'(a);
        #1;
        while (!req_ready) step();
        step();
        req_valid = 1'b0;
        #1;
        chk(!rsp_valid && !req_ready, "R6", "C1 ready/valid", {30'd0, req_ready, rsp_valid}, 32'd0);
        quiet = 1'b1;
        for (int k = 2; k <= 6; k++) begin
            step();
            if (rsp_valid || req_ready) quiet = 1'b0;
        end
        chk(quiet, "R5", "early output or ready during fill", 32'(quiet), 32'd1);
        for (int w = 0; w < 4; w++) begin
            step();
            chk(rsp_valid && rsp_data == expw(base + w), "R3", "line word",
                rsp_data, expw(base + w));
            chk(rsp_last == (w == 3), "R4", "last flag", 32'(rsp_last), 32'(w == 3));
            if (w < 3) chk(!req_ready, "R6", "ready during burst", 32'(req_ready), 32'd0);
        end
        step();
        chk(lat_cycles == 8'd11, "R5", "lat_cycles", 32'(lat_cycles), 32'd11);
        chk(!rsp_valid && req_ready, "R6", "after burst", {30'd0, req_ready, rsp_valid}, 32'd2);
    endtask

    // Single-word read: accept C0, word at C7 with last
    task automatic single_req(input int a);
        bit quiet;
        @(negedge clk);
        req_valid = 1'b1; req_single = 1'b1; req_addr = 6'(a);
        #1;
        while (!req_ready) step();
        step();
        req_valid = 1'b0;
        quiet = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            if (k > 1) step();
            if (rsp_valid) quiet = 1'b0;
        end
        chk(quiet, "R7", "early single output", 32'(quiet), 32'd1);
        step();
        chk(rsp_valid && rsp_last && rsp_data == expw(a), "R2", "single word (R7)",
            rsp_data, expw(a));
        step();
        chk(!rsp_valid, "R7", "single output lasts one cycle", 32'(rsp_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int lowcnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(req_ready && !rsp_valid && !rsp_last && lat_cycles == 8'd0, "R1", "reset state",
            {lat_cycles, 21'd0, req_ready, rsp_valid, rsp_last}, 32'h0000_0004);

        // R3, R5, R6: every address as a line request (low bits ignored)
        for (int a = 0; a < 64; a++) line_req(a);
        // R2, R7: every address as a single-word read
        for (int a = 0; a < 64; a++) single_req(a);

        // R8: same bank (5 then 9, both bank 1) stalls six cycles
        @(negedge clk);
        req_valid = 1'b1; req_single = 1'b1; req_addr = 6'd5;
        #1;
        chk(req_ready, "R8", "first single accepted", 32'(req_ready), 32'd1);
        step();
        req_addr = 6'd9;
        #1;
        lowcnt = 0;
        for (int k = 1; k <= 6; k++) begin
            if (k > 1) step();
            if (!req_ready) lowcnt++;
        end
        chk(lowcnt == 6, "R8", "stall cycles on busy bank", 32'(lowcnt), 32'd6);
        step();
        chk(req_ready, "R8", "bank free at C7", 32'(req_ready), 32'd1);
        chk(rsp_valid && rsp_data == expw(5), "R8", "first word at C7", rsp_data, expw(5));
        step();
        req_valid = 1'b0;
        for (int k = 9; k <= 14; k++) step();
        chk(rsp_valid && rsp_last && rsp_data == expw(9), "R8", "stalled word at C14",
            rsp_data, expw(9));
        step();

        // R8: different bank (5 then 6) accepted back to back
        @(negedge clk);
        req_valid = 1'b1; req_single = 1'b1; req_addr = 6'd5;
        #1;
        step();
        req_addr = 6'd6;
        #1;
        chk(req_ready, "R8", "free bank accepted next cycle", 32'(req_ready), 32'd1);
        step();
        req_valid = 1'b0;
        for (int k = 3; k <= 7; k++) step();
        chk(rsp_valid && rsp_data == expw(5), "R8", "overlap word 5", rsp_data, expw(5));
        step();
        chk(rsp_valid && rsp_last && rsp_data == expw(6), "R8", "overlap word 6",
            rsp_data, expw(6));
        step();

        // R9: line request held while a single occupies bank 3
        @(negedge clk);
        req_valid = 1'b1; req_single = 1'b1; req_addr = 6'd3;
        #1;
        step();
        req_single = 1'b0; req_addr = 6'd40;
        #1;
        lowcnt = 0;
        for (int k = 1; k <= 6; k++) begin
            if (k > 1) step();
            if (!req_ready) lowcnt++;
        end
        chk(lowcnt == 6, "R9", "line held by busy bank", 32'(lowcnt), 32'd6);
        step();
        chk(req_ready, "R9", "line accepted at C7", 32'(req_ready), 32'd1);
        step();
        req_valid = 1'b0;
        for (int k = 9; k <= 14; k++) step();
        for (int w = 0; w < 4; w++) begin
            if (w > 0) step();
            chk(rsp_valid && rsp_data == expw(40 + w), "R9", "line after single",
                rsp_data, expw(40 + w));
        end
        step();
        chk(lat_cycles == 8'd11, "R5", "lat after held line", 32'(lat_cycles), 32'd11);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule